// File: doc/BRIEF.md
# Serial Bit-Addressed I/O Expander

This block sits on the peripheral side of a serial, bit-addressable I/O bus. A host processor shares one address bus between memory cycles and I/O cycles. A cycle is an I/O cycle only when memory enable (active low) is deasserted. During an I/O cycle, the lower address lines carry a 12-bit bit address. The expander compares the upper part of that bit address against a configurable base. When it matches, the expander claims a window of 16 output bits and 16 input bits, selected by the low four bits of the address.

A rising edge on the I/O strobe writes the serial output bit into the addressed output flip-flop. The addressed input bit is driven back on the serial input line, with a drive-enable that is high only while the port is selected, so other devices can share the line. The top three address lines normally read zero. When they hold a nonzero code as the strobe rises, the cycle is an external instruction: the block raises a one-cycle strobe carrying that code and leaves every output bit alone.

Top module: `bitio_expander`

## Requirements
- R1: While `rst_n` is low, and right after reset, `out_pins` is all zero and `xop_valid` is low.
- R2: A rising edge of `io_strobe`, with `mem_en_n` high, code `addr[14:12]` equal to 0 and bit address `addr[11:0]` in `BASE..BASE+15`, loads `io_dout` into `out_pins[addr[3:0]]` on that clock edge. Every other output bit keeps its value.
- R3: While `mem_en_n` is low, a strobe edge changes no output bit and raises no `xop_valid`, and `io_din_oe` is low.
- R4: A bit write whose bit address lies outside `BASE..BASE+15` changes no output bit.
- R5: A rising strobe edge with `mem_en_n` high and a nonzero code on `addr[14:12]` sets `xop_valid` high for exactly one cycle. `xop_code` carries that code. No output bit changes, whatever the bit address.
- R6: `io_din_oe` is high exactly when `mem_en_n` is high and the bit address lies inside the window. While it is high, `io_din` equals the synchronized `in_pins[addr[3:0]]`; otherwise `io_din` is 0.
- R7: A strobe held high writes only once, at its rising edge. Changing `io_dout` while the strobe stays high changes no output bit.
- R8: `in_pins` reaches `io_din` through `IN_SYNC` flip-flop stages, default 2.
- R9: Strobe edges while `rst_n` is low change no output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 15 | Address bus; bit 14 is the most significant line, bits 11:0 are the I/O bit address |
| mem_en_n | input | 1 | Memory enable, active low; high marks an I/O cycle |
| io_strobe | input | 1 | I/O clock from the host; its rising edge commits a cycle |
| io_dout | input | 1 | Serial output data from the host |
| io_din | output | 1 | Serial input data to the host |
| io_din_oe | output | 1 | Drive enable for `io_din` |
| in_pins | input | 16 | Input bits of the window |
| out_pins | output | 16 | Output latches of the window |
| xop_valid | output | 1 | One-cycle external-instruction strobe |
| xop_code | output | 3 | External-instruction code |

## Verification
Some rules are checked by assertions on every cycle:
- Memory cycles leave the outputs stable.
- The drive-enable never rises during a memory cycle.
- A commit changes at most one output bit.
- The external-instruction strobe lasts one cycle and never coincides with an output change.

Other behaviour only the bench scenarios can show:
- Which bit a write lands in, and the value it takes.
- That every window index reads back the right input level after the synchronizer delay.
- That addresses just outside the window are ignored.
- That a held strobe writes once.
- That strobes during reset are ignored.

// File: rtl/bitio_pkg.sv
`timescale 1ns/1ps
package bitio_pkg;

   typedef enum logic [1:0] {
      CYC_NONE = 2'd0,
      CYC_BIT  = 2'd1,
      CYC_XOP  = 2'd2
   } cyc_kind_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bitio_decode.sv
`timescale 1ns/1ps
module bitio_decode
   import bitio_pkg::*;
#(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned CODE_W    = 3,
   parameter int unsigned PORT_BITS = 16,
   parameter int unsigned BASE      = 'h0A0,
   localparam int unsigned BA_W     = ADDR_W - CODE_W,
   localparam int unsigned IDX_W    = $clog2(PORT_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              mem_en_n,
   input  logic              strobe,
   output logic              sel,
   output logic [IDX_W-1:0]  idx,
   output logic [CODE_W-1:0] code,
   output cyc_kind_e         kind
);
   localparam logic [BA_W-1:0] BASE_V = BA_W'(BASE);

   if (!is_pow2(PORT_BITS)) begin : g_bad_width
      $error("PORT_BITS must be a power of two");
   end
   if (BASE % PORT_BITS != 0) begin : g_bad_base
      $error("BASE must be aligned to PORT_BITS");
   end
   if (IDX_W >= BA_W) begin : g_bad_split
      $error("window does not fit the bit address");
   end

   logic [BA_W-1:0] bit_addr;
   logic            strobe_q;
   logic            rise;
   logic            in_window;

   assign bit_addr  = addr[BA_W-1:0];
   assign code      = addr[ADDR_W-1 -: CODE_W];
   assign idx       = bit_addr[IDX_W-1:0];
   assign in_window = (bit_addr[BA_W-1:IDX_W] == BASE_V[BA_W-1:IDX_W]);
   assign sel       = mem_en_n && in_window;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe;
   end

   assign rise = strobe && !strobe_q;

   always_comb begin
      kind = CYC_NONE;
      if (mem_en_n && rise) begin
         if (code != '0)     kind = CYC_XOP;
         else if (in_window) kind = CYC_BIT;
      end
   end

   AST_KIND_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != CYC_NONE) |-> mem_en_n);   // R3

endmodule

// File: rtl/bitio_out_bank.sv
`timescale 1ns/1ps
module bitio_out_bank #(
   parameter int unsigned PORT_BITS = 16,
   localparam int unsigned IDX_W    = $clog2(PORT_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic                 wr_data,
   output logic [PORT_BITS-1:0] out_q
);
   for (genvar b = 0; b < PORT_BITS; b++) begin : g_bit
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   out_q[b] <= 1'b0;
         else if (hit) out_q[b] <= wr_data;
      end
   end

   AST_ONE_BIT_PER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_q ^ $past(out_q)) <= 1);   // R2

   AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q != $past(out_q)) |-> $past(wr_en));   // R4

endmodule

// File: rtl/bitio_in_mux.sv
`timescale 1ns/1ps
module bitio_in_mux #(
   parameter int unsigned PORT_BITS   = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = $clog2(PORT_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PORT_BITS-1:0] pins,
   input  logic                 sel,
   input  logic [IDX_W-1:0]     idx,
   input  logic                 mem_en_n,
   output logic                 din,
   output logic                 oe
);
   logic [PORT_BITS-1:0] synced;

   if (SYNC_STAGES == 0) begin : g_direct
      assign synced = pins;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0][PORT_BITS-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain[0] <= pins;
            for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
         end
      end
      assign synced = chain[SYNC_STAGES-1];
   end

   assign oe  = sel;
   assign din = sel ? synced[idx] : 1'b0;

   AST_OE_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> mem_en_n);   // R6

endmodule

// File: rtl/bitio_expander.sv
`timescale 1ns/1ps
module bitio_expander
   import bitio_pkg::*;
#(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned CODE_W    = 3,
   parameter int unsigned PORT_BITS = 16,
   parameter int unsigned BASE      = 'h0A0,
   parameter int unsigned IN_SYNC   = 2,
   localparam int unsigned IDX_W    = $clog2(PORT_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 mem_en_n,
   input  logic                 io_strobe,
   input  logic                 io_dout,
   output logic                 io_din,
   output logic                 io_din_oe,
   input  logic [PORT_BITS-1:0] in_pins,
   output logic [PORT_BITS-1:0] out_pins,
   output logic                 xop_valid,
   output logic [CODE_W-1:0]    xop_code
);
   if (CODE_W == 0 || CODE_W >= ADDR_W) begin : g_bad_code
      $error("CODE_W must leave room for a bit address");
   end

   logic              sel;
   logic [IDX_W-1:0]  idx;
   logic [CODE_W-1:0] code;
   cyc_kind_e         kind;

   bitio_decode #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .PORT_BITS(PORT_BITS), .BASE(BASE)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .addr(addr), .mem_en_n(mem_en_n),
      .strobe(io_strobe), .sel(sel), .idx(idx), .code(code), .kind(kind)
   );

   bitio_out_bank #(.PORT_BITS(PORT_BITS)) u_out (
      .clk(clk), .rst_n(rst_n), .wr_en(kind == CYC_BIT), .wr_idx(idx),
      .wr_data(io_dout), .out_q(out_pins)
   );

   bitio_in_mux #(.PORT_BITS(PORT_BITS), .SYNC_STAGES(IN_SYNC)) u_in (
      .clk(clk), .rst_n(rst_n), .pins(in_pins), .sel(sel), .idx(idx),
      .mem_en_n(mem_en_n), .din(io_din), .oe(io_din_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xop_valid <= 1'b0;
         xop_code  <= '0;
      end else begin
         xop_valid <= (kind == CYC_XOP);
         if (kind == CYC_XOP) xop_code <= code;
      end
   end

   AST_MEM_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_en_n |=> $stable(out_pins));   // R3

   AST_XOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      xop_valid |=> !xop_valid);   // R5

   AST_XOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      xop_valid |-> $stable(out_pins));   // R5

   AST_XOP_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      xop_valid |-> (xop_code != '0));   // R5

endmodule

// File: tb/tb_bitio_expander.sv
`timescale 1ns/1ps
module tb_bitio_expander;
   localparam int unsigned BASE = 'h0A0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] addr = '0;
   logic        mem_en_n = 1'b0;
   logic        io_strobe = 1'b0;
   logic        io_dout = 1'b0;
   logic        io_din, io_din_oe;
   logic [15:0] in_pins = '0;
   logic [15:0] out_pins;
   logic        xop_valid;
   logic [2:0]  xop_code;

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_out = '0;

   always #5 clk = ~clk;

   bitio_expander dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .mem_en_n(mem_en_n),
      .io_strobe(io_strobe), .io_dout(io_dout), .io_din(io_din),
      .io_din_oe(io_din_oe), .in_pins(in_pins), .out_pins(out_pins),
      .xop_valid(xop_valid), .xop_code(xop_code)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one strobe pulse; returns xop_valid / code seen the cycle after the edge
   task automatic pulse(input logic [2:0] code, input logic [11:0] ba,
                        input logic d, input logic io_cycle,
                        output logic xv, output logic [2:0] xc);
      @(negedge clk);
      addr = {code, ba}; io_dout = d; mem_en_n = io_cycle; io_strobe = 1'b1;
      @(negedge clk);
      io_strobe = 1'b0;
      xv = xop_valid; xc = xop_code;
      @(negedge clk);
   endtask

   function automatic logic in_win(input logic [11:0] ba);
      return (ba >= 12'(BASE)) && (ba < 12'(BASE + 16));
   endfunction

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic xv;
      logic [2:0] xc;
      // R1 / R9: reset state, strobes during reset ignored
      repeat (2) @(negedge clk);
      chk(out_pins == 16'h0, "R1 reset out", 32'(out_pins), 32'h0);
      chk(xop_valid == 1'b0, "R1 reset xop", 32'(xop_valid), 32'h0);
      for (int k = 0; k < 4; k++) begin
         pulse(3'd0, 12'(BASE + k), 1'b1, 1'b1, xv, xc);
      end
      chk(out_pins == 16'h0, "R9 strobe in reset", 32'(out_pins), 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(out_pins == 16'h0, "R1 after reset", 32'(out_pins), 32'h0);

      // R2: walk each bit, set then clear neighbours stay
      for (int i = 0; i < 16; i++) begin
         pulse(3'd0, 12'(BASE + i), 1'b1, 1'b1, xv, xc);
         exp_out[i] = 1'b1;
         chk(out_pins == exp_out, "R2 set bit", 32'(out_pins), 32'(exp_out));
      end
      for (int i = 0; i < 16; i += 3) begin
         pulse(3'd0, 12'(BASE + i), 1'b0, 1'b1, xv, xc);
         exp_out[i] = 1'b0;
         chk(out_pins == exp_out, "R2 clear bit", 32'(out_pins), 32'(exp_out));
      end

      // R3: memory cycles ignored
      for (int i = 0; i < 16; i++) begin
         pulse(3'd0, 12'(BASE + i), ~exp_out[i], 1'b0, xv, xc);
         chk(out_pins == exp_out, "R3 mem write", 32'(out_pins), 32'(exp_out));
         chk(xv == 1'b0, "R3 mem xop", 32'(xv), 32'h0);
      end
      pulse(3'd5, 12'(BASE), 1'b1, 1'b0, xv, xc);
      chk(xv == 1'b0, "R3 mem code", 32'(xv), 32'h0);
      @(negedge clk); mem_en_n = 1'b0; addr = {3'd0, 12'(BASE + 2)}; #1;
      chk(io_din_oe == 1'b0, "R3 mem oe", 32'(io_din_oe), 32'h0);

      // R4: addresses outside the window
      begin
         logic [11:0] outs [4];
         outs[0] = 12'(BASE - 1); outs[1] = 12'(BASE + 16);
         outs[2] = 12'h000;       outs[3] = 12'hFFF;
         for (int j = 0; j < 4; j++) begin
            pulse(3'd0, outs[j], ~exp_out[outs[j][3:0]], 1'b1, xv, xc);
            chk(out_pins == exp_out, "R4 outside", 32'(out_pins), 32'(exp_out));
         end
      end

      // R5: every nonzero code
      for (int c = 1; c < 8; c++) begin
         pulse(3'(c), 12'(BASE + c), ~exp_out[c], 1'b1, xv, xc);
         chk(xv == 1'b1, "R5 xop valid", 32'(xv), 32'h1);
         chk(xc == 3'(c), "R5 xop code", 32'(xc), 32'(c));
         chk(xop_valid == 1'b0, "R5 one cycle", 32'(xop_valid), 32'h0);
         chk(out_pins == exp_out, "R5 no write", 32'(out_pins), 32'(exp_out));
      end

      // R7: held strobe writes once
      @(negedge clk);
      addr = {3'd0, 12'(BASE + 7)}; mem_en_n = 1'b1; io_dout = 1'b1; io_strobe = 1'b1;
      exp_out[7] = 1'b1;
      @(negedge clk); io_dout = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_pins == exp_out, "R7 held strobe", 32'(out_pins), 32'(exp_out));
      io_strobe = 1'b0;
      @(negedge clk);

      // R6 / R8: input readback for all indices and patterns
      begin
         logic [15:0] pats [3];
         pats[0] = 16'hA5C3; pats[1] = 16'h0F0F; pats[2] = 16'hFFFE;
         for (int p = 0; p < 3; p++) begin
            in_pins = pats[p];
            @(negedge clk); mem_en_n = 1'b1; addr = {3'd0, 12'(BASE)}; #1;
            chk(io_din == pats[(p + 2) % 3][0], "R8 not yet synced",
                32'(io_din), 32'(pats[(p + 2) % 3][0]));
            repeat (2) @(negedge clk);
            for (int i = 0; i < 16; i++) begin
               addr = {3'd0, 12'(BASE + i)}; #1;
               chk(io_din_oe == 1'b1, "R6 oe in window", 32'(io_din_oe), 32'h1);
               chk(io_din == pats[p][i], "R6 din level", 32'(io_din), 32'(pats[p][i]));
            end
            for (int a = int'(BASE) - 20; a < int'(BASE) + 36; a += 7) begin
               addr = {3'd0, 12'(a)}; #1;
               chk(io_din_oe == in_win(12'(a)), "R6 oe sweep",
                   32'(io_din_oe), 32'(in_win(12'(a))));
               if (!in_win(12'(a)))
                  chk(io_din == 1'b0, "R6 din idle", 32'(io_din), 32'h0);
            end
            @(negedge clk);
         end
      end

      // R1: reset again clears latches
      @(negedge clk); rst_n = 1'b0; #1;
      chk(out_pins == 16'h0, "R1 async clear", 32'(out_pins), 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule